// File: doc/BRIEF.md
# Adapter interrupt indicator setter

This block sits behind the message-signalled doorbell of one PCI function. Each doorbell write carries a vector number. The block turns that number into one bit set in a byte-addressed per-vector indicator area. It then sets one bit in a summary area. It requests an adapter interrupt only if the summary byte held no bits before the update. Both updates are atomic read-modify-write byte operations on a simple locked memory port. The interrupt controller and the address mapping are outside the block.

The doorbell input is a valid/ready stream. The block raises `db_ready` only while it is idle. A write is taken on the rising edge where `db_valid` and `db_ready` are both high. `db_ready` then stays low until the indicator update, the summary update and any pulse on `irq_o` or `route_err` are done. A sender must hold `db_valid` and `db_data` stable until the transfer is taken. Doorbell data is little-endian, so bit 0 of `db_data` is the least significant bit of the vector.

On the memory side, a request (`mem_req`) is held with its address, direction and data stable until `mem_ready` is sampled high. Read data returns on a later cycle with `mem_rvalid`. `mem_rerr` on that cycle marks a failed access.

Top module: `ind_setter`

## Requirements
- R1: The vector number is `db_data[10:0]`. Bits above bit 10 have no effect on which byte or bit is set.
- R2: A doorbell write taken while `fn_enabled` is low is dropped. It causes no memory request, no indicator or summary change and no interrupt, and `db_ready` is high again on the next cycle.
- R3: With n = `cfg_ind_off` + vector, the indicator byte address is `cfg_ind_base` + n/8 (integer division). The mask is 0x80 >> (n mod 8), so bit number 0 is the byte's most significant bit.
- R4: Each byte update is one read followed by one write of (old value OR mask). `mem_lock` is high from the read request until the write is accepted, and no write is issued without `mem_lock`.
- R5: The summary update starts only after the indicator update has completed. With m = `cfg_sum_off`, it targets byte `cfg_sum_base` + m/8 with mask 0x80 >> (m mod 8).
- R6: `irq_o` is a one-cycle pulse. It is raised, with `irq_isc` equal to the `cfg_isc` value captured when the doorbell was taken, only when the summary byte read back as zero.
- R7: A pulse on `rd_req` is answered on the next cycle by `rd_valid` with `rd_data` all ones.
- R8: A read that returns `mem_rerr` causes no write to that byte and a one-cycle `route_err` pulse at the end of the operation. A failed indicator byte still lets the summary update run. A failed summary byte suppresses the interrupt.
- R9: `db_ready` is low from the acceptance cycle through the cycle carrying the `irq_o`/`route_err` pulses. A memory request keeps its address and direction while `mem_ready` is low.
- R10: After reset `db_ready` is high, and `mem_req`, `mem_lock`, `irq_o` and `route_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_valid | input | 1 | Doorbell write valid |
| db_ready | output | 1 | Block idle, can take a doorbell write |
| db_data | input | 32 | Doorbell write data (vector in low bits) |
| rd_req | input | 1 | Doorbell read strobe |
| rd_valid | output | 1 | Doorbell read response valid |
| rd_data | output | 32 | Doorbell read data (all ones when valid) |
| fn_enabled | input | 1 | Function is in the enabled state |
| cfg_ind_base | input | 32 | Indicator area byte base address |
| cfg_ind_off | input | 16 | Indicator bit offset |
| cfg_sum_base | input | 32 | Summary area byte base address |
| cfg_sum_off | input | 16 | Summary bit offset |
| cfg_isc | input | 3 | Interruption subclass |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_lock | output | 1 | Memory locked for an atomic byte update |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read byte |
| mem_rerr | input | 1 | Read failed |
| irq_o | output | 1 | Adapter interrupt request pulse |
| irq_isc | output | 3 | Subclass of the requested interrupt |
| route_err | output | 1 | Indicator access error pulse |

## Verification
The interrupt request and the routing-error report can appear in the same cycle. This happens when the indicator byte faults but the summary byte is reachable and was clear. The bench provokes it by moving the indicator base into the faulting window of its memory model, with the summary byte cleared beforehand. A scoreboard entry then expects both `irq_o` and `route_err` together with the captured subclass. The bench also checks that the summary byte was set while the indicator byte was never written.

// File: rtl/ind_pkg.sv
package ind_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_IND,
    SQ_SUM,
    SQ_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    RM_IDLE,
    RM_RD,
    RM_WAIT,
    RM_WR
  } rmw_state_t;

  // Bit number 0 is the most significant bit of the byte.
  function automatic logic [7:0] msb_first_mask(input logic [2:0] bitnum);
    return 8'h80 >> bitnum;
  endfunction

endpackage

// File: rtl/ind_locate.sv
module ind_locate #(
  parameter int AW    = 32,
  parameter int OFF_W = 16,
  parameter int VEC_W = 11
) (
  input  logic [AW-1:0]    base,
  input  logic [OFF_W-1:0] bit_off,
  input  logic [VEC_W-1:0] vec,
  output logic [AW-1:0]    byte_addr,
  output logic [7:0]       mask
);
  import ind_pkg::*;

  localparam int IDX_W = ((OFF_W > VEC_W) ? OFF_W : VEC_W) + 1;

  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    byte_ofs;

  always_comb begin
    idx       = IDX_W'(bit_off) + IDX_W'(vec);
    byte_ofs  = AW'(idx[IDX_W-1:3]);
    byte_addr = base + byte_ofs;
    mask      = msb_first_mask(idx[2:0]);
  end

endmodule

// File: rtl/byte_rmw.sv
module byte_rmw #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    mask,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_lock,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_rerr,
  output logic          done,
  output logic          err,
  output logic [7:0]    old_val
);
  import ind_pkg::*;

  rmw_state_t    st;
  logic [AW-1:0] addr_q;
  logic [7:0]    mask_q;
  logic [7:0]    old_q;
  logic          done_q;
  logic          err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RM_IDLE;
      addr_q <= '0;
      mask_q <= '0;
      old_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        RM_IDLE: begin
          if (start) begin
            addr_q <= addr;
            mask_q <= mask;
            err_q  <= 1'b0;
            st     <= RM_RD;
          end
        end
        RM_RD: begin
          if (mem_ready) st <= RM_WAIT;
        end
        RM_WAIT: begin
          if (mem_rvalid) begin
            if (mem_rerr) begin
              old_q  <= 8'hFF;
              err_q  <= 1'b1;
              done_q <= 1'b1;
              st     <= RM_IDLE;
            end else begin
              old_q <= mem_rdata;
              st    <= RM_WR;
            end
          end
        end
        RM_WR: begin
          if (mem_ready) begin
            done_q <= 1'b1;
            st     <= RM_IDLE;
          end
        end
        default: st <= RM_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (st == RM_RD) || (st == RM_WR);
    mem_we    = (st == RM_WR);
    mem_lock  = (st != RM_IDLE);
    mem_addr  = addr_q;
    mem_wdata = old_q | mask_q;
    done      = done_q;
    err       = err_q;
    old_val   = old_q;
  end

endmodule

// File: rtl/ind_setter.sv
module ind_setter #(
  parameter int AW    = 32,
  parameter int DB_W  = 32,
  parameter int OFF_W = 16,
  parameter int VEC_W = 11,
  parameter int ISC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_valid,
  output logic             db_ready,
  input  logic [DB_W-1:0]  db_data,
  input  logic             rd_req,
  output logic             rd_valid,
  output logic [DB_W-1:0]  rd_data,
  input  logic             fn_enabled,
  input  logic [AW-1:0]    cfg_ind_base,
  input  logic [OFF_W-1:0] cfg_ind_off,
  input  logic [AW-1:0]    cfg_sum_base,
  input  logic [OFF_W-1:0] cfg_sum_off,
  input  logic [ISC_W-1:0] cfg_isc,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_lock,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_ready,
  input  logic             mem_rvalid,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_rerr,
  output logic             irq_o,
  output logic [ISC_W-1:0] irq_isc,
  output logic             route_err
);
  import ind_pkg::*;

  localparam int N_AREA = 2;  // 0: per-vector indicator, 1: summary

  seq_state_t       state;
  logic             start_q;
  logic             sel_sum;
  logic [VEC_W-1:0] vec_q;
  logic [ISC_W-1:0] isc_q;
  logic             err_pend;
  logic             irq_q;
  logic             err_q;
  logic             rd_valid_q;

  logic [AW-1:0]    area_base [N_AREA];
  logic [OFF_W-1:0] area_off  [N_AREA];
  logic [VEC_W-1:0] area_vec  [N_AREA];
  logic [AW-1:0]    area_addr [N_AREA];
  logic [7:0]       area_mask [N_AREA];

  always_comb begin
    area_base[0] = cfg_ind_base;
    area_off[0]  = cfg_ind_off;
    area_vec[0]  = vec_q;
    area_base[1] = cfg_sum_base;
    area_off[1]  = cfg_sum_off;
    area_vec[1]  = '0;
  end

  for (genvar g = 0; g < N_AREA; g++) begin : g_loc
    ind_locate #(
      .AW    (AW),
      .OFF_W (OFF_W),
      .VEC_W (VEC_W)
    ) u_loc (
      .base      (area_base[g]),
      .bit_off   (area_off[g]),
      .vec       (area_vec[g]),
      .byte_addr (area_addr[g]),
      .mask      (area_mask[g])
    );
  end

  logic [AW-1:0] tgt_addr;
  logic [7:0]    tgt_mask;
  logic          rmw_done;
  logic          rmw_err;
  logic [7:0]    rmw_old;

  always_comb begin
    tgt_addr = sel_sum ? area_addr[1] : area_addr[0];
    tgt_mask = sel_sum ? area_mask[1] : area_mask[0];
  end

  byte_rmw #(.AW(AW)) u_rmw (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_q),
    .addr       (tgt_addr),
    .mask       (tgt_mask),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_lock   (mem_lock),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .mem_rerr   (mem_rerr),
    .done       (rmw_done),
    .err        (rmw_err),
    .old_val    (rmw_old)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      start_q    <= 1'b0;
      sel_sum    <= 1'b0;
      vec_q      <= '0;
      isc_q      <= '0;
      err_pend   <= 1'b0;
      irq_q      <= 1'b0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      start_q    <= 1'b0;
      rd_valid_q <= rd_req;
      case (state)
        SQ_IDLE: begin
          if (db_valid && fn_enabled) begin
            vec_q    <= db_data[VEC_W-1:0];
            isc_q    <= cfg_isc;
            sel_sum  <= 1'b0;
            err_pend <= 1'b0;
            start_q  <= 1'b1;
            state    <= SQ_IND;
          end
        end
        SQ_IND: begin
          if (rmw_done) begin
            err_pend <= rmw_err;
            sel_sum  <= 1'b1;
            start_q  <= 1'b1;
            state    <= SQ_SUM;
          end
        end
        SQ_SUM: begin
          if (rmw_done) begin
            irq_q <= !rmw_err && (rmw_old == 8'h00);
            err_q <= err_pend || rmw_err;
            state <= SQ_FIN;
          end
        end
        SQ_FIN: begin
          irq_q <= 1'b0;
          err_q <= 1'b0;
          state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    db_ready  = (state == SQ_IDLE);
    irq_o     = irq_q;
    irq_isc   = isc_q;
    route_err = err_q;
    rd_valid  = rd_valid_q;
    rd_data   = rd_valid_q ? '1 : '0;
  end

endmodule

// File: rtl/ind_setter_chk.sv
module ind_setter_chk #(
  parameter int AW    = 32,
  parameter int DB_W  = 32,
  parameter int ISC_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            db_valid,
  input logic            db_ready,
  input logic            rd_req,
  input logic            rd_valid,
  input logic [DB_W-1:0] rd_data,
  input logic            fn_enabled,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_lock,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_ready,
  input logic            mem_rvalid,
  input logic            mem_rerr,
  input logic            irq_o,
  input logic            route_err
);

  // R2
  disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && db_ready && !fn_enabled) |=> (!mem_req && db_ready));

  // R4
  lock_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_lock);

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R7
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rd_valid && (rd_data == '1)));

  // R8
  no_write_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && mem_rerr) |=> !(mem_req && mem_we));

  // R9
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || route_err) |-> !db_ready);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R10
  idle_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_ready |-> (!mem_lock && !mem_req));

endmodule

bind ind_setter ind_setter_chk #(.AW(AW), .DB_W(DB_W), .ISC_W(ISC_W)) u_chk (.*);

// File: tb/sim_ind_setter.sv
module sim_ind_setter;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          db_valid = 1'b0;
  logic          db_ready;
  logic [DW-1:0] db_data = '0;
  logic          rd_req = 1'b0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          fn_enabled = 1'b1;
  logic [AW-1:0] cfg_ind_base = 32'h10;
  logic [15:0]   cfg_ind_off = '0;
  logic [AW-1:0] cfg_sum_base = 32'h40;
  logic [15:0]   cfg_sum_off = '0;
  logic [2:0]    cfg_isc = 3'd5;
  logic          mem_req, mem_we, mem_lock;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_ready = 1'b1;
  logic          mem_rvalid = 1'b0;
  logic [7:0]    mem_rdata = '0;
  logic          mem_rerr = 1'b0;
  logic          irq_o;
  logic [2:0]    irq_isc;
  logic          route_err;

  always #4 clk = ~clk;

  ind_setter u0 (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_ready(db_ready),
    .db_data(db_data), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .fn_enabled(fn_enabled), .cfg_ind_base(cfg_ind_base), .cfg_ind_off(cfg_ind_off),
    .cfg_sum_base(cfg_sum_base), .cfg_sum_off(cfg_sum_off), .cfg_isc(cfg_isc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .irq_o(irq_o), .irq_isc(irq_isc),
    .route_err(route_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit stall_mode = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] wlog [$];
  logic [4:0] sb [$];   // {irq, err, isc}

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic bit bad_addr(input logic [AW-1:0] a);
    return a[7:4] == 4'hF;
  endfunction

  // memory model: faulting window is bytes 0xF0..0xFF
  always @(negedge clk) begin
    if (stall_mode) mem_ready <= ~mem_ready;
    else            mem_ready <= 1'b1;
  end

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_rerr   <= 1'b0;
    if (rst_n && mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[7:0]] = mem_wdata;
        wlog.push_back(mem_addr[7:0]);
        // R4: no write without the lock
        if (!mem_lock) check(1'b0, "R4 lock", 0, 1);
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[7:0]];
        mem_rerr   <= bad_addr(mem_addr);
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (irq_o || route_err)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R6/R8 unexpected event", {irq_o, route_err, irq_isc}, 0);
      end else begin
        logic [4:0] e;
        e = sb.pop_front();
        check({irq_o, route_err, irq_isc} == e, "R6/R8 event", {irq_o, route_err, irq_isc}, e);
      end
    end
  end

  task automatic doorbell(input logic [DW-1:0] d, input string tag);
    logic [10:0] vec;
    int idx, sidx;
    logic [7:0] ia, sa, im, sm, old;
    bit ib, sbd, irq, err;
    logic [7:0] exp_w [$];
    vec  = d[10:0];  // R1
    idx  = int'(cfg_ind_off) + int'(vec);
    ia   = 8'(cfg_ind_base + AW'(idx / 8));
    im   = 8'h80 >> (idx % 8);
    sidx = int'(cfg_sum_off);
    sa   = 8'(cfg_sum_base + AW'(sidx / 8));
    sm   = 8'h80 >> (sidx % 8);
    ib   = bad_addr({24'h0, ia});
    sbd  = bad_addr({24'h0, sa});
    wlog.delete();
    if (fn_enabled) begin
      if (!ib) begin exp_mem[ia] = exp_mem[ia] | im; exp_w.push_back(ia); end
      old = exp_mem[sa];
      if (!sbd) begin exp_mem[sa] = exp_mem[sa] | sm; exp_w.push_back(sa); end
      irq = !sbd && (old == 8'h00);
      err = ib || sbd;
      if (irq || err) sb.push_back({irq, err, cfg_isc});
    end
    @(negedge clk);
    db_valid = 1'b1;
    db_data  = d;
    while (!db_ready) @(negedge clk);
    @(negedge clk);
    db_valid = 1'b0;
    if (fn_enabled)
      check(db_ready == 1'b0, {"R9 busy ", tag}, db_ready, 0);
    else
      check(db_ready == 1'b1, {"R2 ready ", tag}, db_ready, 1);
    while (!db_ready) @(negedge clk);
    @(negedge clk);
    check(sb.size() == 0, {"R6 event seen ", tag}, sb.size(), 0);
    check(wlog.size() == exp_w.size(), {"R5 write count ", tag}, wlog.size(), exp_w.size());
    for (int i = 0; i < exp_w.size() && i < wlog.size(); i++)
      check(wlog[i] == exp_w[i], {"R5 write order ", tag}, wlog[i], exp_w[i]);
    check(mem[ia] == exp_mem[ia], {"R3 indicator byte ", tag}, mem[ia], exp_mem[ia]);
    check(mem[sa] == exp_mem[sa], {"R5 summary byte ", tag}, mem[sa], exp_mem[sa]);
    sb.delete();
  endtask

  task automatic clear_byte(input logic [7:0] a);
    mem[a] = 8'h00;
    exp_mem[a] = 8'h00;
  endtask

  bit done_flag = 1'b0;

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(db_ready == 1'b1, "R10 ready", db_ready, 1);
    check(mem_req == 1'b0 && mem_lock == 1'b0, "R10 mem idle", {mem_req, mem_lock}, 0);
    check(irq_o == 1'b0 && route_err == 1'b0, "R10 no pulses", {irq_o, route_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 doorbell read
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check(rd_valid == 1'b1 && rd_data == '1, "R7 read ones", rd_data, 32'hFFFF_FFFF);

    // R3/R6 first vector: 0x10 bit7, summary clear -> irq
    doorbell(32'h0, "vec0");
    check(mem[8'h10] == 8'h80, "R3 msb first", mem[8'h10], 8'h80);
    // R6 summary already set -> no irq
    doorbell(32'h2, "vec2");
    check(mem[8'h10] == 8'hA0, "R3 accumulate", mem[8'h10], 8'hA0);

    // R3/R5 byte crossing: off 5 + vec 6 = bit 11 -> 0x11 mask 0x10; summary off 13 -> 0x41 mask 0x04
    cfg_ind_off = 16'd5; cfg_sum_off = 16'd13; cfg_isc = 3'd2;
    doorbell(32'h6, "cross");
    check(mem[8'h11] == 8'h10, "R3 cross byte", mem[8'h11], 8'h10);
    check(mem[8'h41] == 8'h04, "R5 summary bit", mem[8'h41], 8'h04);

    // R1 upper bits ignored: 0xABCDF803 -> vector 3, bit 8 -> 0x11 mask 0x80
    doorbell(32'hABCD_F803, "vecmask");
    check(mem[8'h11] == 8'h90, "R1 vector mask", mem[8'h11], 8'h90);

    // R2 disabled: dropped
    clear_byte(8'h41);
    fn_enabled = 1'b0;
    doorbell(32'h7, "disabled");
    check(mem[8'h41] == 8'h00, "R2 summary untouched", mem[8'h41], 0);
    check(wlog.size() == 0, "R2 no writes", wlog.size(), 0);
    fn_enabled = 1'b1;

    // R8 indicator fault, summary clear: error and interrupt in one cycle
    cfg_ind_base = 32'hF0; cfg_ind_off = 16'd0; cfg_isc = 3'd6;
    doorbell(32'h1, "indfault");
    check(mem[8'h41] == 8'h04, "R8 summary set after fault", mem[8'h41], 8'h04);

    // R8 summary fault: error, no irq, indicator written
    cfg_ind_base = 32'h20; cfg_sum_base = 32'hF8;
    doorbell(32'h9, "sumfault");
    check(mem[8'h21] == 8'h40, "R8 indicator kept", mem[8'h21], 8'h40);

    // R9 stalled memory: off 3 + vec 100 = bit 103 -> 0x2C mask 0x01
    cfg_sum_base = 32'h40; cfg_ind_off = 16'd3; cfg_isc = 3'd1;
    clear_byte(8'h41);
    stall_mode = 1'b1;
    doorbell(32'd100, "stall");
    check(mem[8'h2C] == 8'h01, "R9 stalled update", mem[8'h2C], 8'h01);
    stall_mode = 1'b0;

    repeat (4) @(negedge clk);
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule